// File: doc/BRIEF.md
# Integer add/logic execution unit

This block is the integer arithmetic and bitwise lane of a 64-bit RISC-style core. Each cycle it may accept one operation: an opcode, two source values already read from the register file, a 22-bit immediate field, the index of the second source register, a flag that swaps the first source for an immediate, and a 2-bit shift count. One clock edge later it presents the 64-bit result together with a valid strobe.

The arithmetic side covers plain and carry-in-one addition and subtraction, immediate forms whose width depends on the operation (14 bits for add, 8 bits for subtract), a 22-bit immediate add that is only legal when the register operand comes from one of the four lowest-numbered registers, and a shift-left-then-add with a shift of one to four places. The bitwise side covers AND, OR, XOR and AND-with-inverted-second-operand, each with either a register or a sign-extended 8-bit immediate as its first operand. All arithmetic wraps modulo 2^64. A wide-immediate add that names a register outside the permitted set raises an illegal-operand flag and returns zero.

Top module: `int_alu_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `out_valid`, `illegal_op` and `result` are all cleared to zero, whatever the other inputs are.
- R2: `out_valid` follows `in_valid` of the previous rising edge; `result` and `illegal_op` change only on an edge where `in_valid` is high, `result` holds its value across idle cycles and `illegal_op` is low after an idle cycle.
- R3: With `use_imm` low, opcode 0 returns `src_a + src_b` and opcode 2 returns `src_a - src_b`, both modulo 2^64.
- R4: Opcode 1 returns `src_a + src_b + 1` and opcode 3 returns `src_a - src_b - 1`, modulo 2^64; `use_imm` has no effect on them.
- R5: Opcode 0 with `use_imm` high returns `sext(imm[13:0]) + src_b`; bits 21:14 of `imm` have no effect.
- R6: Opcode 2 with `use_imm` high returns `sext(imm[7:0]) - src_b`; bits 21:8 of `imm` have no effect.
- R7: Opcode 4 with `src_idx` of 0, 1, 2 or 3 returns `sext(imm[21:0]) + src_b` with `illegal_op` low.
- R8: Opcode 4 with `src_idx` of 4 or more returns zero with `illegal_op` high for that result.
- R9: Opcode 5 returns `(src_a << (sh_cnt + 1)) + src_b`, modulo 2^64, for `sh_cnt` 0 to 3 (shift of 1 to 4).
- R10: With `use_imm` low, opcodes 6, 7, 8 and 9 return `src_a & src_b`, `src_a | src_b`, `src_a ^ src_b` and `src_a & ~src_b`.
- R11: With `use_imm` high, opcodes 6 to 9 use `sext(imm[7:0])` in place of `src_a`.
- R12: Opcodes 10 to 15 return zero, and every opcode other than 4 leaves `illegal_op` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see requirements) |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 22 | Immediate field; the low 14, 8 or all 22 bits are used by the form |
| src_idx | input | 7 | Register index of the second operand, checked by the wide-immediate add |
| use_imm | input | 1 | Replace the first operand by the form's immediate |
| sh_cnt | input | 2 | Shift-and-add count minus one |
| out_valid | output | 1 | `result` carries a new value |
| result | output | 64 | Registered result |
| illegal_op | output | 1 | The last accepted operation was a wide-immediate add from a disallowed register |

## Verification
The illegal-operand check and the result path meet in the same cycle: a wide-immediate add with an out-of-range register index must both force the sum to zero and raise the flag, while the very next operation or idle cycle must drop the flag again. The bench provokes this with directed back-to-back sequences (legal index 3, illegal index 4, illegal index 127, then an idle cycle) and with random indices biased toward the 0 to 7 range, and judges every output against a bench model that computes the sum and the flag separately from the requirement text.

// File: rtl/int_alu_pkg.sv
// Package: int_alu_pkg
// Shared operation codes for the integer add/logic execution unit.
// Assumes a 4-bit opcode field; codes 10..15 are unassigned.
package int_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD      = 4'd0,
        OP_ADD_P1   = 4'd1,
        OP_SUB      = 4'd2,
        OP_SUB_M1   = 4'd3,
        OP_ADD_WIDE = 4'd4,
        OP_SHL_ADD  = 4'd5,
        OP_AND      = 4'd6,
        OP_OR       = 4'd7,
        OP_XOR      = 4'd8,
        OP_AND_NOT  = 4'd9
    } alu_op_e;

endpackage

// File: rtl/int_alu_sext.sv
// Module: int_alu_sext
// Sign-extends an IN_W-bit field to OUT_W bits.
// Assumes IN_W >= 1; if IN_W >= OUT_W the field is truncated instead.
module int_alu_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    generate
        if (IN_W >= OUT_W) begin : g_trunc
            // Field already as wide as the datapath: keep the low bits.
            assign dout = din[OUT_W-1:0];
        end else begin : g_ext
            localparam int PAD_W = OUT_W - IN_W;
            // Replicate the field's top bit into the upper positions.
            assign dout = {{PAD_W{din[IN_W-1]}}, din};
        end
    endgenerate

endmodule

// File: rtl/int_alu_arith.sv
// Module: int_alu_arith
// Arithmetic lane: one shared adder serves plain, carry-in-one, immediate,
// wide-immediate and shift-then-add forms. Subtraction uses the inverted
// second operand with the carry-in chosen per form.
// Assumes op is already an integer-unit opcode; non-arithmetic codes leave
// arith_hit low and the sum is don't-care.
module int_alu_arith
    import int_alu_pkg::*;
#(
    parameter int DATA_W         = 64,
    parameter int IMM_W          = 22,
    parameter int ADD_IMM_W      = 14,
    parameter int SUB_IMM_W      = 8,
    parameter int IDX_W          = 7,
    parameter int WIDE_SRC_LIMIT = 4,
    parameter int MAX_SHIFT      = 4,
    parameter int SHC_W          = 2
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic              use_imm,
    input  logic [SHC_W-1:0]  sh_cnt,
    output logic [DATA_W-1:0] arith_res,
    output logic              arith_hit,
    output logic              wide_bad
);

    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(WIDE_SRC_LIMIT);

    logic [DATA_W-1:0] add_imm_ext;
    logic [DATA_W-1:0] sub_imm_ext;
    logic [DATA_W-1:0] wide_imm_ext;
    logic [DATA_W-1:0] shl_opts [MAX_SHIFT];
    logic [DATA_W-1:0] shl_sel;
    logic [DATA_W-1:0] opnd_x;
    logic [DATA_W-1:0] opnd_y;
    logic              carry_in;
    logic              invert_y;
    logic [DATA_W-1:0] sum;
    logic              wide_form;

    int_alu_sext #(.IN_W(ADD_IMM_W), .OUT_W(DATA_W)) u_add_ext (
        .din  (imm[ADD_IMM_W-1:0]),
        .dout (add_imm_ext)
    );

    int_alu_sext #(.IN_W(SUB_IMM_W), .OUT_W(DATA_W)) u_sub_ext (
        .din  (imm[SUB_IMM_W-1:0]),
        .dout (sub_imm_ext)
    );

    int_alu_sext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_wide_ext (
        .din  (imm),
        .dout (wide_imm_ext)
    );

    // One pre-shifted copy of src_a per legal shift amount (1..MAX_SHIFT).
    for (genvar k = 0; k < MAX_SHIFT; k++) begin : g_shl
        assign shl_opts[k] = src_a << (k + 1);
    end

    // Pick the shifted copy; counts past the table clamp to the largest shift.
    always_comb begin
        if (int'(sh_cnt) < MAX_SHIFT) begin
            shl_sel = shl_opts[sh_cnt];
        end else begin
            shl_sel = shl_opts[MAX_SHIFT-1];
        end
    end

    // Route operands, inversion and carry-in for the selected form.
    always_comb begin
        opnd_x    = src_a;
        opnd_y    = src_b;
        carry_in  = 1'b0;
        invert_y  = 1'b0;
        arith_hit = 1'b1;
        wide_form = 1'b0;
        case (op)
            OP_ADD: begin
                opnd_x = use_imm ? add_imm_ext : src_a;
            end
            OP_ADD_P1: begin
                carry_in = 1'b1;
            end
            OP_SUB: begin
                opnd_x   = use_imm ? sub_imm_ext : src_a;
                invert_y = 1'b1;
                carry_in = 1'b1;
            end
            OP_SUB_M1: begin
                invert_y = 1'b1;
            end
            OP_ADD_WIDE: begin
                opnd_x    = wide_imm_ext;
                wide_form = 1'b1;
            end
            OP_SHL_ADD: begin
                opnd_x = shl_sel;
            end
            default: begin
                opnd_x    = '0;
                opnd_y    = '0;
                arith_hit = 1'b0;
            end
        endcase
    end

    // Single shared adder with optional operand inversion.
    assign sum = opnd_x + (invert_y ? ~opnd_y : opnd_y)
               + {{(DATA_W-1){1'b0}}, carry_in};

    // Wide-immediate form is only legal from the lowest register indices.
    assign wide_bad = wide_form && (src_idx >= IDX_LIMIT);

    // Suppress the sum of an illegal wide-immediate add.
    assign arith_res = wide_bad ? '0 : sum;

endmodule

// File: rtl/int_alu_logic.sv
// Module: int_alu_logic
// Bitwise lane: AND, OR, XOR and AND-with-inverted-second-operand, with the
// first operand taken from src_a or from a sign-extended short immediate.
// Assumes op is an integer-unit opcode; other codes leave logic_hit low.
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int LOG_IMM_W = 8
) (
    input  logic [OP_W-1:0]      op,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    input  logic [LOG_IMM_W-1:0] imm_lo,
    input  logic                 use_imm,
    output logic [DATA_W-1:0]    logic_res,
    output logic                 logic_hit
);

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] first;

    int_alu_sext #(.IN_W(LOG_IMM_W), .OUT_W(DATA_W)) u_log_ext (
        .din  (imm_lo),
        .dout (imm_ext)
    );

    // First operand is the register or the extended immediate.
    assign first = use_imm ? imm_ext : src_a;

    // Evaluate the selected bitwise function.
    always_comb begin
        logic_hit = 1'b1;
        case (op)
            OP_AND:     logic_res = first & src_b;
            OP_OR:      logic_res = first | src_b;
            OP_XOR:     logic_res = first ^ src_b;
            OP_AND_NOT: logic_res = first & ~src_b;
            default: begin
                logic_res = '0;
                logic_hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/int_alu_unit.sv
// Module: int_alu_unit
// Integer add/logic execution unit: combines the arithmetic and bitwise
// lanes and registers the result, a valid strobe and an illegal-operand flag.
// Assumes operands arrive already read from the register file; one operation
// per cycle, result one edge later. Reset is synchronous, active low.
module int_alu_unit
    import int_alu_pkg::*;
#(
    parameter int DATA_W         = 64,
    parameter int IMM_W          = 22,
    parameter int ADD_IMM_W      = 14,
    parameter int SUB_IMM_W      = 8,
    parameter int LOG_IMM_W      = 8,
    parameter int IDX_W          = 7,
    parameter int WIDE_SRC_LIMIT = 4,
    parameter int MAX_SHIFT      = 4,
    localparam int SHC_W         = (MAX_SHIFT > 1) ? $clog2(MAX_SHIFT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic              use_imm,
    input  logic [SHC_W-1:0]  sh_cnt,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);

    logic [DATA_W-1:0] arith_res;
    logic              arith_hit;
    logic              wide_bad;
    logic [DATA_W-1:0] logic_res;
    logic              logic_hit;
    logic [DATA_W-1:0] next_res;

    int_alu_arith #(
        .DATA_W         (DATA_W),
        .IMM_W          (IMM_W),
        .ADD_IMM_W      (ADD_IMM_W),
        .SUB_IMM_W      (SUB_IMM_W),
        .IDX_W          (IDX_W),
        .WIDE_SRC_LIMIT (WIDE_SRC_LIMIT),
        .MAX_SHIFT      (MAX_SHIFT),
        .SHC_W          (SHC_W)
    ) u_arith (
        .op        (op),
        .src_a     (src_a),
        .src_b     (src_b),
        .imm       (imm),
        .src_idx   (src_idx),
        .use_imm   (use_imm),
        .sh_cnt    (sh_cnt),
        .arith_res (arith_res),
        .arith_hit (arith_hit),
        .wide_bad  (wide_bad)
    );

    int_alu_logic #(
        .DATA_W    (DATA_W),
        .LOG_IMM_W (LOG_IMM_W)
    ) u_logic (
        .op        (op),
        .src_a     (src_a),
        .src_b     (src_b),
        .imm_lo    (imm[LOG_IMM_W-1:0]),
        .use_imm   (use_imm),
        .logic_res (logic_res),
        .logic_hit (logic_hit)
    );

    // Merge lanes; unassigned opcodes produce zero.
    always_comb begin
        if (arith_hit) begin
            next_res = arith_res;
        end else if (logic_hit) begin
            next_res = logic_res;
        end else begin
            next_res = '0;
        end
    end

    // Output register: capture on accepted operations, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            illegal_op <= 1'b0;
            result     <= '0;
        end else begin
            out_valid  <= in_valid;
            illegal_op <= in_valid && wide_bad;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end

endmodule

// File: rtl/int_alu_unit_chk.sv
// Module: int_alu_unit_chk
// Property checker for int_alu_unit, attached by bind below.
// Assumes the top's default opcode encoding from int_alu_pkg.
module int_alu_unit_chk
    import int_alu_pkg::*;
#(
    parameter int DATA_W         = 64,
    parameter int IMM_W          = 22,
    parameter int IDX_W          = 7,
    parameter int WIDE_SRC_LIMIT = 4,
    parameter int SHC_W          = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm,
    input logic [IDX_W-1:0]  src_idx,
    input logic              use_imm,
    input logic [SHC_W-1:0]  sh_cnt,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              illegal_op
);

    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(WIDE_SRC_LIMIT);

    logic [DATA_W-1:0] wide_exp;
    logic [DATA_W-1:0] p1_exp;
    logic [DATA_W-1:0] shl_exp;
    logic [DATA_W-1:0] andn_exp;

    // Independent expected values for selected forms.
    assign wide_exp = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} + src_b;
    assign p1_exp   = src_a + src_b + DATA_W'(1);
    assign shl_exp  = (src_a << (int'(sh_cnt) + 1)) + src_b;
    assign andn_exp = src_a & ~src_b;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !illegal_op && $stable(result)));

    assert_plus_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADD_P1) |=> (result == $past(p1_exp)));

    assert_wide_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADD_WIDE && src_idx < IDX_LIMIT)
        |=> (!illegal_op && result == $past(wide_exp)));

    assert_wide_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADD_WIDE && src_idx >= IDX_LIMIT)
        |=> (illegal_op && result == '0));

    assert_shift_add_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SHL_ADD) |=> (result == $past(shl_exp)));

    assert_and_not_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_AND_NOT && !use_imm) |=> (result == $past(andn_exp)));

    assert_only_wide_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_ADD_WIDE) |=> !illegal_op);

endmodule

bind int_alu_unit int_alu_unit_chk #(
    .DATA_W         (DATA_W),
    .IMM_W          (IMM_W),
    .IDX_W          (IDX_W),
    .WIDE_SRC_LIMIT (WIDE_SRC_LIMIT),
    .SHC_W          (SHC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .src_a      (src_a),
    .src_b      (src_b),
    .imm        (imm),
    .src_idx    (src_idx),
    .use_imm    (use_imm),
    .sh_cnt     (sh_cnt),
    .out_valid  (out_valid),
    .result     (result),
    .illegal_op (illegal_op)
);

// File: tb/int_alu_unit_tb.sv
// Bench: int_alu_unit_tb
// Directed corner cases plus seeded random operations, checked against a
// bench model written from the requirements.
module int_alu_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;
    localparam int WATCHDOG   = 200000;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [21:0] imm;
    logic [6:0]  src_idx;
    logic        use_imm;
    logic [1:0]  sh_cnt;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal_op;

    int          n_checks;
    int          n_errors;
    logic [63:0] last_res;
    bit          finished;

    int_alu_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op         (op),
        .src_a      (src_a),
        .src_b      (src_b),
        .imm        (imm),
        .src_idx    (src_idx),
        .use_imm    (use_imm),
        .sh_cnt     (sh_cnt),
        .out_valid  (out_valid),
        .result     (result),
        .illegal_op (illegal_op)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] sx(input logic [63:0] v, input int w);
        logic [63:0] m;
        m = v << (64 - w);
        return 64'($signed(m) >>> (64 - w));
    endfunction

    function automatic logic [63:0] model_res(input logic [3:0] o, input logic [63:0] a,
                                              input logic [63:0] b, input logic [21:0] im,
                                              input logic [6:0] idx, input logic ui,
                                              input logic [1:0] sh);
        logic [63:0] f;
        f = ui ? sx({42'd0, im}, 8) : a;
        case (o)
            4'd0: return ui ? sx({42'd0, im}, 14) + b : a + b;
            4'd1: return a + b + 64'd1;
            4'd2: return ui ? sx({42'd0, im}, 8) - b : a - b;
            4'd3: return a - b - 64'd1;
            4'd4: return (idx < 7'd4) ? sx({42'd0, im}, 22) + b : 64'd0;
            4'd5: return (a << (int'(sh) + 1)) + b;
            4'd6: return f & b;
            4'd7: return f | b;
            4'd8: return f ^ b;
            4'd9: return f & ~b;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic ui, input logic [6:0] idx);
        case (o)
            4'd0: return ui ? "R5" : "R3";
            4'd1, 4'd3: return "R4";
            4'd2: return ui ? "R6" : "R3";
            4'd4: return (idx < 7'd4) ? "R7" : "R8";
            4'd5: return "R9";
            4'd6, 4'd7, 4'd8, 4'd9: return ui ? "R11" : "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Present one operation at a falling edge, check it at the next falling edge.
    task automatic issue(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                         input logic [21:0] im, input logic [6:0] idx, input logic ui,
                         input logic [1:0] sh);
        logic [63:0] er;
        string       t;
        in_valid = 1'b1; op = o; src_a = a; src_b = b; imm = im;
        src_idx = idx; use_imm = ui; sh_cnt = sh;
        er = model_res(o, a, b, im, idx, ui, sh);
        t  = tag_of(o, ui, idx);
        @(negedge clk);
        check("R2", "out_valid", {63'd0, out_valid}, 64'd1);
        check(t, "result", result, er);
        check((o == 4'd4) ? t : "R12", "illegal_op", {63'd0, illegal_op},
              {63'd0, (o == 4'd4) && (idx >= 7'd4)});
        last_res = er;
    endtask

    // Idle cycle with scrambled operands: nothing may change (R2).
    task automatic idle();
        in_valid = 1'b0; op = 4'($urandom); src_a = {$urandom, $urandom};
        src_b = {$urandom, $urandom}; imm = 22'($urandom); src_idx = 7'($urandom);
        use_imm = 1'($urandom); sh_cnt = 2'($urandom);
        @(negedge clk);
        check("R2", "idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R2", "idle result hold", result, last_res);
        check("R2", "idle illegal_op", {63'd0, illegal_op}, 64'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b1; op = 4'd0; src_a = 64'd5; src_b = 64'd9;
        imm = 22'd0; src_idx = 7'd9; use_imm = 1'b0; sh_cnt = 2'd0;
        @(negedge clk);
        check("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1", "reset result", result, 64'd0);
        check("R1", "reset illegal_op", {63'd0, illegal_op}, 64'd0);
        op = 4'd4;
        @(negedge clk);
        check("R1", "reset result second cycle", result, 64'd0);
        check("R1", "reset illegal second cycle", {63'd0, illegal_op}, 64'd0);
        rst_n = 1'b1;
        last_res = 64'd0;
    endtask

    initial begin
        n_checks = 0; n_errors = 0; finished = 0; last_res = '0;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0;
        imm = '0; src_idx = '0; use_imm = 1'b0; sh_cnt = '0;
        @(negedge clk);
        do_reset();

        // R3: wrap-around of plain add and subtract
        issue(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 22'd0, 7'd0, 1'b0, 2'd0);
        check("R3", "add wraps to zero", result, 64'd0);
        issue(4'd2, 64'd0, 64'd1, 22'd0, 7'd0, 1'b0, 2'd0);
        check("R3", "sub wraps to all ones", result, 64'hFFFF_FFFF_FFFF_FFFF);
        // R4: carry-in forms, use_imm set and ignored
        issue(4'd1, 64'd5, 64'd7, 22'h3F_FFFF, 7'd0, 1'b1, 2'd0);
        check("R4", "add plus one", result, 64'd13);
        issue(4'd3, 64'd5, 64'd5, 22'h3F_FFFF, 7'd0, 1'b1, 2'd0);
        check("R4", "sub minus one", result, 64'hFFFF_FFFF_FFFF_FFFF);
        // R5: 14-bit negative immediate, upper field bits set and ignored
        issue(4'd0, 64'hDEAD, 64'd10000, 22'h3FE000, 7'd50, 1'b1, 2'd0);
        check("R5", "add imm -8192", result, 64'd1808);
        // R6: 8-bit immediate minus register
        issue(4'd2, 64'hBEEF, 64'd1, 22'h3FFF80, 7'd0, 1'b1, 2'd0);
        check("R6", "imm -128 minus 1", result, 64'hFFFF_FFFF_FFFF_FF7F);
        // R7 and R8: wide-immediate boundary on the register index
        issue(4'd4, 64'd0, 64'd0, 22'h200000, 7'd3, 1'b0, 2'd0);
        check("R7", "wide min imm", result, 64'hFFFF_FFFF_FFE0_0000);
        issue(4'd4, 64'd0, 64'd100, 22'h1FFFFF, 7'd0, 1'b0, 2'd0);
        issue(4'd4, 64'd0, 64'd100, 22'h000123, 7'd4, 1'b0, 2'd0);
        check("R8", "illegal flag idx 4", {63'd0, illegal_op}, 64'd1);
        issue(4'd4, 64'd0, 64'd100, 22'h000123, 7'd127, 1'b0, 2'd0);
        issue(4'd0, 64'd1, 64'd2, 22'd0, 7'd127, 1'b0, 2'd0);
        issue(4'd4, 64'd0, 64'd5, 22'h000001, 7'd64, 1'b0, 2'd0);
        idle();
        // R9: smallest and largest shift, top bits shifted out
        issue(4'd5, 64'hC000_0000_0000_0001, 64'd3, 22'd0, 7'd0, 1'b0, 2'd0);
        check("R9", "shift 1", result, 64'h8000_0000_0000_0005);
        issue(4'd5, 64'hF000_0000_0000_0003, 64'd1, 22'd0, 7'd0, 1'b0, 2'd3);
        check("R9", "shift 4", result, 64'h0000_0000_0000_0031);
        // R10 and R11: bitwise forms
        issue(4'd9, 64'hFF00_FF00_FF00_FF00, 64'hF0F0_F0F0_F0F0_F0F0, 22'd0, 7'd0, 1'b0, 2'd0);
        check("R10", "and-not regs", result, 64'h0F00_0F00_0F00_0F00);
        issue(4'd9, 64'd0, 64'h0000_0000_0000_00F0, 22'h3FFF80, 7'd0, 1'b1, 2'd0);
        check("R11", "and-not imm -128", result, 64'hFFFF_FFFF_FFFF_FF00);
        issue(4'd7, 64'd0, 64'd0, 22'h00007F, 7'd0, 1'b1, 2'd0);
        issue(4'd8, 64'h1234, 64'h1234, 22'd0, 7'd0, 1'b0, 2'd0);
        issue(4'd6, 64'hFFFF, 64'h0F0F, 22'd0, 7'd0, 1'b0, 2'd0);
        // R12: unassigned opcodes give zero, no flag
        issue(4'd15, 64'hFFFF, 64'hFFFF, 22'h3FFFFF, 7'd99, 1'b1, 2'd3);
        check("R12", "unassigned zero", result, 64'd0);
        issue(4'd10, 64'h1, 64'h1, 22'd0, 7'd5, 1'b0, 2'd0);
        idle();

        // Seeded random mix, index biased toward the wide-add boundary.
        for (int i = 0; i < N_RANDOM; i++) begin
            if (($urandom % 8) == 0) begin
                idle();
            end else begin
                logic [6:0] idx;
                idx = (($urandom % 2) == 0) ? 7'($urandom % 8) : 7'($urandom);
                issue(4'($urandom % 12), {$urandom, $urandom}, {$urandom, $urandom},
                      22'($urandom), idx, 1'($urandom), 2'($urandom));
            end
            if (i == N_RANDOM / 2) begin
                do_reset();
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule